// File: doc/BRIEF.md
# CPU Clock Source Selector and Prescaler

This block decides which source drives the CPU clock enable of a small microcontroller core and how fast that enable pulses. Three sources are modelled as single-cycle tick inputs inside one synchronous domain: a crystal input, an on-chip ring oscillator and a slow subsystem clock. The crystal and ring paths go through a power-of-two prescaler. The subsystem path is always halved. The output `cpu_en` pulses once per CPU clock period.

Software talks to the block over a byte-wide register port. A byte write or a single-bit write can update any register. A source-select register picks the source and the prescale code. A ring-control register holds a stop request for the ring oscillator. A read-only status register reports which source is active and whether the ring oscillator runs. A new selection is applied only when the current CPU clock period ends, so no period is ever cut short.

The stop request is stored as written. It takes effect only when three conditions hold. The static option input must allow stopping. The ring oscillator must be neither the active source nor the requested one. The main-select status must already be set.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: After reset, both writable registers read 0x00 and the ring oscillator is the active source. `main_sel_st` and `sub_active` are 0, `ring_run` is 1 and `cpu_en` is 0.
- R2: With the crystal source active and prescale code c, `cpu_en` pulses once every 2^c crystal ticks. Codes 5, 6 and 7 behave as code 4 (divide by 16).
- R3: With the subsystem source active, `cpu_en` pulses once every 2 subsystem ticks. The sub-select bit overrides the crystal/ring choice.
- R4: With the ring oscillator active, `cpu_en` pulses once every 2^c ring ticks, using the same code saturation as R2.
- R5: A change of source or prescale code takes effect only in the cycle in which `cpu_en` pulses. The period in progress completes with the old setting.
- R6: The ring-control register (address 1) keeps only bit 0, the stop request. Bits 7..1 read as 0. A byte write updates bit 0, and a single-bit write changes bit 0 only when the bit index is 0.
- R7: Reads of the ring-control register return the stored stop bit even while the stop is blocked.
- R8: `ring_run` goes low only when all of these hold: the stop bit is 1, `stop_option` is 1, `main_sel_st` is 1, and the ring oscillator is neither active nor requested. While it is low, ring ticks are ignored.
- R9: When software requests the ring oscillator while a stop is in force, `ring_run` returns to 1 in the cycle after the write, before the switch completes.
- R10: The source-select register (address 0) has these fields: bit 0 chooses the crystal (1) or the ring (0), bit 1 selects the subsystem source, and bits 4..2 hold the prescale code. Bits 7..5 read as 0 and ignore writes.
- R11: The status register (address 2) reads bit 0 as `main_sel_st`, bit 1 as `sub_active` and bit 2 as `ring_run`, with the other bits 0. Address 3 reads 0.
- R12: `main_sel_st` sets when a switch to the crystal completes and clears when a switch to the ring completes. It is left unchanged by switches into or out of the subsystem source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_tick | input | 1 | Crystal source tick |
| ring_tick | input | 1 | Ring oscillator tick |
| sub_tick | input | 1 | Subsystem source tick |
| stop_option | input | 1 | Static option: 1 allows the ring oscillator to be stopped |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Byte write data |
| reg_we | input | 1 | Byte write strobe |
| reg_bit_we | input | 1 | Single-bit write strobe |
| reg_bit_idx | input | 3 | Bit index for a single-bit write |
| reg_bit_val | input | 1 | Value for a single-bit write |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cpu_en | output | 1 | CPU clock enable pulse |
| ring_run | output | 1 | Ring oscillator is running |
| main_sel_st | output | 1 | Main-select status (crystal chosen over ring) |
| sub_active | output | 1 | Subsystem source is active |

## Verification
Some properties are checked on every cycle. A stopped ring oscillator always implies an enabled option and a set main-select status. The upper ring-control bits always read zero. Changes of the source status happen only on a `cpu_en` pulse. Subsystem pulses are never back to back. The exact prescale ratios, code saturation, full period completion after a mid-period change, the forced restart on returning to the ring, and the register read-back through byte and bit writes can only be shown by the bench scenarios. The bench does this with directed sequences and with a cycle-level model under random ticks and writes.

// File: rtl/clkc_pkg.sv
package clkc_pkg;

   // prescale code width in the source-select register
   localparam int CODE_W = 3;

   localparam int ADDR_SEL  = 0;
   localparam int ADDR_RING = 1;
   localparam int ADDR_STAT = 2;

   typedef enum logic [1:0] {
      SRC_RING = 2'd0,
      SRC_MAIN = 2'd1,
      SRC_SUB  = 2'd2
   } clk_src_e;

   // subsystem select overrides the crystal/ring choice
   function automatic clk_src_e decode_src(input logic main_bit, input logic sub_bit);
      if (sub_bit)       return SRC_SUB;
      else if (main_bit) return SRC_MAIN;
      else               return SRC_RING;
   endfunction

endpackage

// File: rtl/clkc_bitreg.sv
module clkc_bitreg #(
   parameter int               ADDR_W = 2,
   parameter logic [ADDR_W-1:0] ADDR  = '0,
   parameter logic [7:0]        MASK  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              we,
   input  logic              bit_we,
   input  logic [2:0]        bit_idx,
   input  logic              bit_val,
   output logic [7:0]        q
);

   logic hit;
   assign hit = (addr == ADDR);

   // masked-off data bits have no storage
   logic unused_wd;
   assign unused_wd = ^(wdata & ~MASK);

   for (genvar b = 0; b < 8; b++) begin : g_bit
      logic bq;
      if (MASK[b]) begin : g_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bq <= 1'b0;
            else if (hit && we)
               bq <= wdata[b];
            else if (hit && bit_we && (bit_idx == 3'(b)))
               bq <= bit_val;
         end
      end else begin : g_tie
         assign bq = 1'b0;
      end
      assign q[b] = bq;
   end

endmodule

// File: rtl/clkc_prescaler.sv
module clkc_prescaler
   import clkc_pkg::*;
#(
   parameter int DIV_STEPS = 5,
   parameter int SUB_DIV   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              main_tick,
   input  logic              ring_tick,
   input  logic              sub_tick,
   input  clk_src_e          req_src,
   input  logic [CODE_W-1:0] req_code,
   output logic              cpu_en,
   output clk_src_e          act_src,
   output logic              main_sel_st
);

   localparam int CNT_W = (DIV_STEPS > 2) ? DIV_STEPS - 1 : 1;
   localparam logic [CODE_W-1:0] MAX_SH = CODE_W'(DIV_STEPS - 1);

   clk_src_e          act_src_q;
   logic [CODE_W-1:0] act_code_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              mcs_q;
   logic              en_q;

   logic              src_tick;
   logic [CODE_W-1:0] sh;
   logic [CNT_W:0]    one_sh;
   logic [CNT_W-1:0]  last;
   logic              fire;

   always_comb begin
      case (act_src_q)
         SRC_MAIN: src_tick = main_tick;
         SRC_SUB:  src_tick = sub_tick;
         default:  src_tick = ring_tick;
      endcase
   end

   // saturate the code, then ratio = 2^sh
   always_comb begin
      sh     = (act_code_q > MAX_SH) ? MAX_SH : act_code_q;
      one_sh = {{CNT_W{1'b0}}, 1'b1} << sh;
      if (act_src_q == SRC_SUB)
         last = CNT_W'(SUB_DIV - 1);
      else
         last = CNT_W'(one_sh - 1'b1);
   end

   assign fire = src_tick && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_src_q  <= SRC_RING;
         act_code_q <= '0;
         cnt_q      <= '0;
         mcs_q      <= 1'b0;
         en_q       <= 1'b0;
      end else begin
         en_q <= fire;
         if (fire) begin
            // period boundary: adopt the requested setting
            act_src_q  <= req_src;
            act_code_q <= req_code;
            cnt_q      <= '0;
            if (req_src == SRC_MAIN)
               mcs_q <= 1'b1;
            else if (req_src == SRC_RING)
               mcs_q <= 1'b0;
         end else if (src_tick) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cpu_en      = en_q;
   assign act_src     = act_src_q;
   assign main_sel_st = mcs_q;

endmodule

// File: rtl/clkc_ring_ctl.sv
module clkc_ring_ctl
   import clkc_pkg::*;
(
   input  logic     stop_req,
   input  logic     stop_option,
   input  logic     main_sel_st,
   input  clk_src_e act_src,
   input  clk_src_e req_src,
   output logic     ring_run
);

   logic ring_needed;

   // ring in use or about to be used must keep running
   assign ring_needed = (act_src == SRC_RING) || (req_src == SRC_RING);
   assign ring_run    = !(stop_req && stop_option && main_sel_st && !ring_needed);

endmodule

// File: rtl/cpu_clk_ctrl.sv
module cpu_clk_ctrl
   import clkc_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int DIV_STEPS = 5,
   parameter int SUB_DIV   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              main_tick,
   input  logic              ring_tick,
   input  logic              sub_tick,
   input  logic              stop_option,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   input  logic              reg_bit_we,
   input  logic [2:0]        reg_bit_idx,
   input  logic              reg_bit_val,
   output logic [7:0]        reg_rdata,
   output logic              cpu_en,
   output logic              ring_run,
   output logic              main_sel_st,
   output logic              sub_active
);

   localparam int         SEL_BITS  = 2 + CODE_W;
   localparam logic [7:0] SEL_MASK  = 8'((1 << SEL_BITS) - 1);
   localparam logic [7:0] RING_MASK = 8'h01;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("cpu_clk_ctrl: ADDR_W must be at least 2");
   end
   if (DIV_STEPS < 1 || DIV_STEPS > (1 << CODE_W)) begin : g_bad_steps
      $error("cpu_clk_ctrl: DIV_STEPS out of range for the code field");
   end
   if (SUB_DIV < 1 || SUB_DIV > (1 << ((DIV_STEPS > 2) ? DIV_STEPS - 1 : 1))) begin : g_bad_sub
      $error("cpu_clk_ctrl: SUB_DIV does not fit the period counter");
   end
   if (SEL_BITS > 8) begin : g_bad_sel
      $error("cpu_clk_ctrl: source-select fields exceed one byte");
   end

   logic [7:0] sel_q;
   logic [7:0] ring_q;
   clk_src_e   req_src;
   clk_src_e   act_src;
   logic       ring_tick_g;

   clkc_bitreg #(.ADDR_W(ADDR_W), .ADDR(ADDR_W'(ADDR_SEL)), .MASK(SEL_MASK)) u_sel (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
      .bit_we(reg_bit_we), .bit_idx(reg_bit_idx), .bit_val(reg_bit_val), .q(sel_q)
   );

   clkc_bitreg #(.ADDR_W(ADDR_W), .ADDR(ADDR_W'(ADDR_RING)), .MASK(RING_MASK)) u_ring (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
      .bit_we(reg_bit_we), .bit_idx(reg_bit_idx), .bit_val(reg_bit_val), .q(ring_q)
   );

   assign req_src = decode_src(sel_q[0], sel_q[1]);

   clkc_ring_ctl u_rctl (
      .stop_req(ring_q[0]), .stop_option(stop_option), .main_sel_st(main_sel_st),
      .act_src(act_src), .req_src(req_src), .ring_run(ring_run)
   );

   assign ring_tick_g = ring_tick && ring_run;

   clkc_prescaler #(.DIV_STEPS(DIV_STEPS), .SUB_DIV(SUB_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .ring_tick(ring_tick_g),
      .sub_tick(sub_tick), .req_src(req_src), .req_code(sel_q[2 +: CODE_W]),
      .cpu_en(cpu_en), .act_src(act_src), .main_sel_st(main_sel_st)
   );

   assign sub_active = (act_src == SRC_SUB);

   always_comb begin
      if (reg_addr == ADDR_W'(ADDR_SEL))
         reg_rdata = sel_q;
      else if (reg_addr == ADDR_W'(ADDR_RING))
         reg_rdata = ring_q;
      else if (reg_addr == ADDR_W'(ADDR_STAT))
         reg_rdata = {5'd0, ring_run, sub_active, main_sel_st};
      else
         reg_rdata = 8'h00;
   end

endmodule

// File: rtl/cpu_clk_ctrl_chk.sv
module cpu_clk_ctrl_chk
   import clkc_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_rdata,
   input logic              stop_option,
   input logic              ring_run,
   input logic              main_sel_st,
   input logic              sub_active,
   input logic              cpu_en
);

   // R6
   ring_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(ADDR_RING)) |-> ((reg_rdata & 8'hFE) == 8'h00));

   // R8
   ring_stop_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ring_run |-> (stop_option && main_sel_st));

   // R5
   mcs_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (main_sel_st != $past(main_sel_st)) |-> cpu_en);

   // R5
   sub_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_active != $past(sub_active)) |-> cpu_en);

   // R3
   sub_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_active && $past(sub_active) && $past(cpu_en)) |-> !cpu_en);

endmodule

bind cpu_clk_ctrl cpu_clk_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
   .stop_option(stop_option), .ring_run(ring_run), .main_sel_st(main_sel_st),
   .sub_active(sub_active), .cpu_en(cpu_en)
);

// File: tb/sim_cpu_clk_ctrl.sv
module sim_cpu_clk_ctrl;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       main_tick = 1'b0, ring_tick = 1'b0, sub_tick = 1'b0;
   logic       stop_option = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic       reg_we = 1'b0, reg_bit_we = 1'b0;
   logic [2:0] reg_bit_idx = 3'd0;
   logic       reg_bit_val = 1'b0;
   logic [7:0] reg_rdata;
   logic       cpu_en, ring_run, main_sel_st, sub_active;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_clk_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .ring_tick(ring_tick),
      .sub_tick(sub_tick), .stop_option(stop_option), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_bit_we(reg_bit_we),
      .reg_bit_idx(reg_bit_idx), .reg_bit_val(reg_bit_val), .reg_rdata(reg_rdata),
      .cpu_en(cpu_en), .ring_run(ring_run), .main_sel_st(main_sel_st),
      .sub_active(sub_active)
   );

   // ---------------- reference model from the requirements ----------------
   logic [7:0] m_sel, m_ring;
   int         m_act, m_code, m_cnt;   // act: 0 ring, 1 crystal, 2 subsystem
   bit         m_mcs, m_en;
   bit         tk, fire;

   function automatic int req_of(input logic [7:0] s);
      return s[1] ? 2 : (s[0] ? 1 : 0);
   endfunction

   function automatic int last_of(input int act, input int code);
      int c;
      if (act == 2) return 1;
      c = (code > 4) ? 4 : code;
      return (1 << c) - 1;
   endfunction

   function automatic bit exp_ring();
      return !(m_ring[0] && stop_option && m_mcs && m_act != 0 && req_of(m_sel) != 0);
   endfunction

   function automatic logic [7:0] exp_rd(input logic [1:0] a);
      case (a)
         2'd0:    return m_sel;
         2'd1:    return m_ring;
         2'd2:    return {5'd0, exp_ring(), (m_act == 2), m_mcs};
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sel <= 8'h00; m_ring <= 8'h00; m_act <= 0; m_code <= 0;
         m_cnt <= 0; m_mcs <= 1'b0; m_en <= 1'b0;
      end else begin
         tk   = (m_act == 1) ? main_tick : (m_act == 2) ? sub_tick : (ring_tick && exp_ring());
         fire = tk && (m_cnt == last_of(m_act, m_code));
         m_en <= fire;
         if (fire) begin
            m_act  <= req_of(m_sel);
            m_code <= int'(m_sel[4:2]);
            m_cnt  <= 0;
            if (req_of(m_sel) == 1) m_mcs <= 1'b1;
            else if (req_of(m_sel) == 0) m_mcs <= 1'b0;
         end else if (tk) begin
            m_cnt <= m_cnt + 1;
         end
         if (reg_we && reg_addr == 2'd0) m_sel <= reg_wdata & 8'h1F;
         else if (reg_bit_we && reg_addr == 2'd0 && reg_bit_idx < 3'd5) m_sel[reg_bit_idx] <= reg_bit_val;
         if (reg_we && reg_addr == 2'd1) m_ring <= reg_wdata & 8'h01;
         else if (reg_bit_we && reg_addr == 2'd1 && reg_bit_idx == 3'd0) m_ring[0] <= reg_bit_val;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // one clock: check read data now, then outputs after the edge
   task automatic advance();
      string t;
      #1;
      case (reg_addr)
         2'd1:    t = "R6";
         2'd2:    t = "R11";
         default: t = "R10";
      endcase
      chk(t, "rdata", 32'(reg_rdata), 32'(exp_rd(reg_addr)));
      @(negedge clk);
      reg_we = 1'b0;
      reg_bit_we = 1'b0;
      t = (m_act == 2) ? "R3" : (m_act == 1) ? "R2" : "R4";
      chk(t, "cpu_en", 32'(cpu_en), 32'(m_en));
      chk("R8", "ring_run", 32'(ring_run), 32'(exp_ring()));
      chk("R12", "main_sel_st", 32'(main_sel_st), 32'(m_mcs));
      chk("R3", "sub_active", 32'(sub_active), 32'(m_act == 2));
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      advance();
   endtask

   task automatic wr_bit(input logic [1:0] a, input logic [2:0] i, input logic v);
      reg_addr = a; reg_bit_idx = i; reg_bit_val = v; reg_bit_we = 1'b1;
      advance();
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_en(output int n);
      n = 0;
      do begin
         advance();
         n++;
      end while (!cpu_en && n < 200);
   endtask

   task automatic count_en(input int cycles, output int cnt);
      cnt = 0;
      for (int i = 0; i < cycles; i++) begin
         advance();
         if (cpu_en) cnt++;
      end
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int n;
      logic [7:0] d;
      int unsigned seed;
      seed = $urandom(32'h00C1_0C4E);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", "cpu_en", 32'(cpu_en), 32'd0);
      chk("R1", "ring_run", 32'(ring_run), 32'd1);
      chk("R1", "main_sel_st", 32'(main_sel_st), 32'd0);
      chk("R1", "sub_active", 32'(sub_active), 32'd0);
      rd(2'd0, d); chk("R1", "sel reg", 32'(d), 32'h00);
      rd(2'd1, d); chk("R1", "ring reg", 32'(d), 32'h00);

      // R2 crystal divide by 4
      ring_tick = 1'b1; main_tick = 1'b1;
      wr(2'd0, 8'h09);
      n = 0;
      while (!main_sel_st && n < 20) begin advance(); n++; end
      count_en(32, n);
      chk("R2", "pulses /4 in 32", 32'(n), 32'd8);

      // R2 code 7 saturates to /16
      wr(2'd0, 8'h1D);
      wait_en(n); wait_en(n);
      count_en(32, n);
      chk("R2", "pulses code7 in 32", 32'(n), 32'd2);

      // R5 change mid-period: old period completes
      wait_en(n);
      wr(2'd0, 8'h01);
      n = 1;
      while (!cpu_en && n < 200) begin advance(); n++; end
      chk("R5", "gap after change", 32'(n), 32'd16);
      wait_en(n);
      chk("R5", "gap with new code", 32'(n), 32'd1);

      // R6 / R7 / R8 ring-control register with option off
      wr(2'd1, 8'hFF);
      rd(2'd1, d); chk("R6", "byte write keeps bit0", 32'(d), 32'h01);
      chk("R8", "option off keeps running", 32'(ring_run), 32'd1);
      chk("R7", "stored stop reads back", 32'(d[0]), 32'd1);
      wr_bit(2'd1, 3'd0, 1'b0);
      rd(2'd1, d); chk("R6", "bit0 clear", 32'(d), 32'h00);
      wr_bit(2'd1, 3'd5, 1'b1);
      rd(2'd1, d); chk("R6", "bit5 write ignored", 32'(d), 32'h00);
      wr_bit(2'd1, 3'd0, 1'b1);
      rd(2'd1, d); chk("R6", "bit0 set", 32'(d), 32'h01);
      stop_option = 1'b1;
      advance();
      chk("R8", "stop honoured", 32'(ring_run), 32'd0);
      rd(2'd2, d); chk("R11", "status ring stopped", 32'(d), 32'h01);

      // R9 request ring while stopped: restarts before switch
      main_tick = 1'b0;
      wr(2'd0, 8'h00);
      chk("R9", "ring forced on", 32'(ring_run), 32'd1);
      chk("R12", "status held before switch", 32'(main_sel_st), 32'd1);
      main_tick = 1'b1;
      advance();
      chk("R12", "cleared on ring switch", 32'(main_sel_st), 32'd0);
      chk("R5", "switch on pulse", 32'(cpu_en), 32'd1);

      // R3 subsystem halves its ticks, status unchanged
      sub_tick = 1'b1;
      wr(2'd0, 8'h02);
      n = 0;
      while (!sub_active && n < 20) begin advance(); n++; end
      count_en(20, n);
      chk("R3", "sub pulses in 20", 32'(n), 32'd10);
      chk("R12", "sub leaves status", 32'(main_sel_st), 32'd0);
      rd(2'd2, d); chk("R11", "status sub", 32'(d), 32'h06);

      // R4 ring with divide by 2
      wr(2'd0, 8'h04);
      n = 0;
      while (sub_active && n < 20) begin advance(); n++; end
      count_en(20, n);
      chk("R4", "ring pulses /2 in 20", 32'(n), 32'd10);

      // R10 source-select field layout
      wr(2'd0, 8'hFF);
      rd(2'd0, d); chk("R10", "upper bits zero", 32'(d), 32'h1F);
      wr_bit(2'd0, 3'd6, 1'b1);
      rd(2'd0, d); chk("R10", "bit6 ignored", 32'(d), 32'h1F);
      wr_bit(2'd0, 3'd1, 1'b0);
      rd(2'd0, d); chk("R10", "bit1 cleared", 32'(d), 32'h1D);
      rd(2'd3, d); chk("R11", "unused address", 32'(d), 32'h00);

      // random phase, checked every cycle against the model
      for (int i = 0; i < 4000; i++) begin
         main_tick = 1'($urandom);
         ring_tick = 1'($urandom);
         sub_tick  = 1'($urandom);
         if ($urandom_range(255) == 0) stop_option = ~stop_option;
         reg_addr = 2'($urandom);
         if ($urandom_range(15) == 0) begin
            reg_wdata = 8'($urandom);
            reg_we = 1'b1;
         end else if ($urandom_range(15) == 0) begin
            reg_bit_idx = 3'($urandom);
            reg_bit_val = 1'($urandom);
            reg_bit_we = 1'b1;
         end
         advance();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule